// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt requests from peripherals and presents them to a processor through a small register file. The request lines are grouped into identical banks of 32. Each bank holds a latched pending word, an enable word, a read-only view of pending lines that are also enabled, a software retrigger word and a routing word. Each bank drives one summary interrupt line toward the processor.

Software reaches the registers through a single-cycle port with separate read and write strobes and a byte address. Banks repeat at a 0x28-byte stride. A pending bit is cleared by writing a one to it. A pending bit whose request is still high latches again at once, so a level source that has not been serviced cannot be lost. Read data comes out of a register one cycle after the read strobe.

Top module: `multi_icu`

## Requirements
- R1: Bank N occupies byte addresses N*0x28 up to N*0x28+0x27. Inside a bank the offsets are: 0x00 pending, 0x08 enable, 0x10 enabled-pending view, 0x18 retrigger, 0x20 routing. Every register is 32 bits wide, and bit i of bank N belongs to request line req_i[N*32+i]. Banks do not alias one another.
- R2: A pending bit is set at the first rising clock edge at which its request input is high. It then stays set until a write to the pending register puts a 1 in that bit position. A 0 in the written data leaves the bit unchanged.
- R3: If a request is still high in the cycle its pending bit is cleared, the bit stays set. Setting takes priority over clearing.
- R4: The enable register takes the full written word and reads back exactly that word.
- R5: The enabled-pending view reads as pending AND enable. Writes to its offset have no effect.
- R6: A 1 in the retrigger register keeps the matching pending bit set, the same as a held request, for as long as the retrigger bit stays 1.
- R7: The summary line of a bank goes high one clock after any bit is set in all three of pending, enable and routing. It goes low one clock after that condition ends.
- R8: While reset is active and for the following cycles, all registers read zero and every summary line is low.
- R9: Reads of addresses beyond the last bank, or addresses not a multiple of 8, return zero. Writes to such addresses change nothing.
- R10: The initialisation sequence leaves no enabled-pending bit and no summary line set while requests are low. The sequence is: enable written 0, pending written all ones, routing written all ones, retrigger written 0.
- R11: Read data is registered. It shows the addressed register as it was at the edge where the read strobe was sampled, and it holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| req_i | input | NUM_MOD*32 | Level-sensitive peripheral requests |
| irq_o | output | NUM_MOD | Per-bank summary interrupt |

## Verification
The assertions assume that request, address and strobe inputs are never unknown and change only between clock edges. They also assume that a pending bit cannot rise without a request or retrigger in the cycle before it. The bench drives every input on the falling edge and starts with all of them at defined values. It waits out the internal reset release before the first access, so every check falls in cycles where the synchronised reset is inactive.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int DATA_W      = 32;
  localparam int BANK_STRIDE = 40;  // 0x28 bytes per bank
  localparam int OFF_PEND    = 0;
  localparam int OFF_ENAB    = 8;
  localparam int OFF_VIEW    = 16;
  localparam int OFF_RETRIG  = 24;
  localparam int OFF_ROUTE   = 32;

  typedef enum logic [2:0] {
    K_NONE,
    K_PEND,
    K_ENAB,
    K_VIEW,
    K_RETRIG,
    K_ROUTE
  } reg_kind_e;
endpackage

// File: rtl/icu_decode.sv
module icu_decode
  import icu_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_MOD-1:0] hit_o,
  output reg_kind_e          kind_o
);
  logic [31:0] addr_ext;
  logic [31:0] offset;
  logic        aligned;

  assign addr_ext = 32'(addr_i);
  assign aligned  = (addr_i[2:0] == 3'b000);

  // one range comparator per bank
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_hit
    localparam logic [31:0] BASE = 32'(m * BANK_STRIDE);
    assign hit_o[m] = aligned && (addr_ext >= BASE) &&
                      (addr_ext < BASE + 32'(BANK_STRIDE));
  end

  always_comb begin
    offset = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (hit_o[m]) offset = addr_ext - 32'(m * BANK_STRIDE);
    end
  end

  always_comb begin
    kind_o = K_NONE;
    if (|hit_o) begin
      case (offset)
        32'(OFF_PEND):   kind_o = K_PEND;
        32'(OFF_ENAB):   kind_o = K_ENAB;
        32'(OFF_VIEW):   kind_o = K_VIEW;
        32'(OFF_RETRIG): kind_o = K_RETRIG;
        32'(OFF_ROUTE):  kind_o = K_ROUTE;
        default:         kind_o = K_NONE;
      endcase
    end
  end

  // at most one bank may claim an address
  always_comb begin
    p_onehot_hit_r1: assert ($onehot0(hit_o) || $isunknown(addr_i));
  end
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  reg_kind_e        kind_i,
  input  logic [LINES-1:0] wdata_i,
  input  logic [LINES-1:0] req_i,
  output logic [LINES-1:0] pend_o,
  output logic [LINES-1:0] enab_o,
  output logic [LINES-1:0] view_o,
  output logic [LINES-1:0] retrig_o,
  output logic [LINES-1:0] route_o,
  output logic             irq_o
);
  logic [LINES-1:0] pend_q, pend_d;
  logic [LINES-1:0] enab_q, retrig_q, route_q;
  logic [LINES-1:0] clr_vec;
  logic             enab_ld, retrig_ld, route_ld;
  logic             irq_q, irq_d;

  // next state
  always_comb begin
    clr_vec   = (wr_i && kind_i == K_PEND) ? wdata_i : '0;
    enab_ld   = wr_i && (kind_i == K_ENAB);
    retrig_ld = wr_i && (kind_i == K_RETRIG);
    route_ld  = wr_i && (kind_i == K_ROUTE);
    // set wins over clear: held levels and retrigger re-latch at once
    pend_d    = (pend_q & ~clr_vec) | req_i | retrig_q;
    irq_d     = |(pend_q & enab_q & route_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      enab_q   <= '0;
      retrig_q <= '0;
      route_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
      if (enab_ld)   enab_q   <= wdata_i;
      if (retrig_ld) retrig_q <= wdata_i;
      if (route_ld)  route_q  <= wdata_i;
    end
  end

  assign pend_o   = pend_q;
  assign enab_o   = enab_q;
  assign view_o   = pend_q & enab_q;
  assign retrig_o = retrig_q;
  assign route_o  = route_q;
  assign irq_o    = irq_q;

  // every request seen at an edge is latched by that edge
  p_req_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(req_i)) == $past(req_i)));

  // a bit only leaves the pending word through a write-one
  p_clear_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

  // a bit only enters the pending word from a request or retrigger
  p_no_spurious_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(req_i) | $past(retrig_q))) == '0));

  // summary follows the gated pending word one clock later
  p_summary_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_q & enab_q & route_q))));
endmodule

// File: rtl/multi_icu.sv
module multi_icu
  import icu_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_MOD*DATA_W-1:0] req_i,
  output logic [NUM_MOD-1:0]        irq_o
);
  localparam int LINES = DATA_W;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_MOD-1:0] hit;
  reg_kind_e          kind;

  icu_decode #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .hit_o  (hit),
    .kind_o (kind)
  );

  logic [LINES-1:0] pend_a   [NUM_MOD];
  logic [LINES-1:0] enab_a   [NUM_MOD];
  logic [LINES-1:0] view_a   [NUM_MOD];
  logic [LINES-1:0] retrig_a [NUM_MOD];
  logic [LINES-1:0] route_a  [NUM_MOD];

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_bank
    icu_bank #(.LINES(LINES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .wr_i     (wr_en_i && hit[m]),
      .kind_i   (kind),
      .wdata_i  (wdata_i),
      .req_i    (req_i[m*LINES +: LINES]),
      .pend_o   (pend_a[m]),
      .enab_o   (enab_a[m]),
      .view_o   (view_a[m]),
      .retrig_o (retrig_a[m]),
      .route_o  (route_a[m]),
      .irq_o    (irq_o[m])
    );
  end

  // read path
  logic [DATA_W-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (hit[m]) begin
        case (kind)
          K_PEND:   rd_d = pend_a[m];
          K_ENAB:   rd_d = enab_a[m];
          K_VIEW:   rd_d = view_a[m];
          K_RETRIG: rd_d = retrig_a[m];
          K_ROUTE:  rd_d = route_a[m];
          default:  rd_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !rd_en_i |=> $stable(rdata_o));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rd_en_i && (hit == '0)) |=> (rdata_o == '0));
endmodule

// File: tb/multi_icu_bench.sv
module multi_icu_bench;
  localparam int NUM_MOD = 5;
  localparam int ADDR_W  = 8;
  localparam int NV      = 26;

  typedef enum logic [1:0] {OP_IDLE, OP_WR, OP_RD} op_e;
  typedef struct packed {
    op_e         op;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read value
    logic [3:0]  rid;    // requirement number
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{OP_RD,   8'h08, 32'h0000_0000, 4'd8},  // R8 enable cleared
    '{OP_WR,   8'h08, 32'hA5A5_0F0F, 4'd4},  // R4
    '{OP_RD,   8'h08, 32'hA5A5_0F0F, 4'd4},  // R4
    '{OP_WR,   8'h30, 32'h0000_FFFF, 4'd1},  // R1 bank 1 enable
    '{OP_RD,   8'h30, 32'h0000_FFFF, 4'd1},  // R1
    '{OP_RD,   8'h08, 32'hA5A5_0F0F, 4'd1},  // R1 no aliasing
    '{OP_WR,   8'h18, 32'h0000_0003, 4'd6},  // R6 retrigger
    '{OP_IDLE, 8'h00, 32'h0000_0000, 4'd6},
    '{OP_RD,   8'h00, 32'h0000_0003, 4'd6},  // R6
    '{OP_RD,   8'h10, 32'h0000_0003, 4'd5},  // R5 view
    '{OP_WR,   8'h10, 32'hFFFF_FFFF, 4'd5},  // R5 write ignored
    '{OP_RD,   8'h10, 32'h0000_0003, 4'd5},  // R5
    '{OP_WR,   8'h18, 32'h0000_0000, 4'd6},  // R6
    '{OP_WR,   8'h00, 32'h0000_0001, 4'd2},  // R2 clear bit 0
    '{OP_RD,   8'h00, 32'h0000_0002, 4'd2},  // R2
    '{OP_WR,   8'h00, 32'h0000_0000, 4'd2},  // R2 zero write
    '{OP_RD,   8'h00, 32'h0000_0002, 4'd2},  // R2
    '{OP_WR,   8'h00, 32'h0000_0002, 4'd2},  // R2
    '{OP_RD,   8'h00, 32'h0000_0000, 4'd2},  // R2
    '{OP_RD,   8'hC8, 32'h0000_0000, 4'd9},  // R9 past last bank
    '{OP_RD,   8'h04, 32'h0000_0000, 4'd9},  // R9 misaligned
    '{OP_WR,   8'h0C, 32'hFFFF_FFFF, 4'd9},  // R9 misaligned write
    '{OP_RD,   8'h08, 32'hA5A5_0F0F, 4'd9},  // R9 enable untouched
    '{OP_WR,   8'hC0, 32'h1234_5678, 4'd1},  // R1 bank 4 routing
    '{OP_RD,   8'hC0, 32'h1234_5678, 4'd1},  // R1
    '{OP_RD,   8'h98, 32'h0000_0000, 4'd1}   // R1 bank 3 routing untouched
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic                  rd_en = 1'b0;
  logic [ADDR_W-1:0]     addr = '0;
  logic [31:0]           wdata = '0;
  logic [31:0]           rdata;
  logic [NUM_MOD*32-1:0] req = '0;
  logic [NUM_MOD-1:0]    irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  multi_icu #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W)) u_multi_icu (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .req_i   (req),
    .irq_o   (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 summary after reset", 32'(irq), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_write(VEC[i].addr, VEC[i].data);
        OP_RD: begin
          do_read(VEC[i].addr, v);
          check($sformatf("R%0d vector %0d", VEC[i].rid, i), v, VEC[i].data);
        end
        default: @(negedge clk);
      endcase
    end

    // R7 timing on bank 2 line 5 (pending 0x50, enable 0x58, view 0x60, route 0x70)
    do_write(8'h58, 32'h0000_0020);
    do_write(8'h70, 32'hFFFF_FFFF);
    @(negedge clk); req[69] = 1'b1;
    @(negedge clk); check("R7 summary not yet", 32'(irq[2]), 32'h0);
    @(negedge clk); check("R7 summary raised", 32'(irq[2]), 32'h1);
    req[69] = 1'b0;
    do_read(8'h50, v); check("R2 pending held after request drops", v, 32'h20);
    do_write(8'h50, 32'h0000_0020);
    check("R7 summary one clock after clear", 32'(irq[2]), 32'h1);
    @(negedge clk); check("R7 summary dropped", 32'(irq[2]), 32'h0);

    // R3 clear while request held
    @(negedge clk); req[69] = 1'b1;
    do_write(8'h50, 32'h0000_0020);
    do_read(8'h50, v); check("R3 set beats clear", v, 32'h20);
    req[69] = 1'b0;
    do_write(8'h50, 32'h0000_0020);
    do_read(8'h50, v); check("R2 cleared once request low", v, 32'h0);

    // R7 routing gate
    do_write(8'h70, 32'h0000_0000);
    @(negedge clk); req[69] = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 unrouted summary low", 32'(irq[2]), 32'h0);
    do_read(8'h60, v); check("R5 view with routing off", v, 32'h20);
    req[69] = 1'b0;

    // R10 initialisation sequence with lines pending
    @(negedge clk); req = '1;
    @(negedge clk); req = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      do_write(8'(m * 40 + 8),  32'h0000_0000);
      do_write(8'(m * 40 + 0),  32'hFFFF_FFFF);
      do_write(8'(m * 40 + 32), 32'hFFFF_FFFF);
      do_write(8'(m * 40 + 24), 32'h0000_0000);
    end
    for (int m = 0; m < NUM_MOD; m++) begin
      do_read(8'(m * 40 + 16), v); check($sformatf("R10 view bank %0d", m), v, 32'h0);
      do_read(8'(m * 40 + 0), v);  check($sformatf("R10 pending bank %0d", m), v, 32'h0);
    end
    repeat (2) @(negedge clk);
    check("R10 all summaries low", 32'(irq), 32'h0);

    // R11 read data holds between reads
    do_write(8'h58, 32'h0000_55AA);
    do_read(8'h58, v); check("R11 read value", v, 32'h55AA);
    addr = 8'h00;
    repeat (3) @(negedge clk);
    check("R11 read data held", rdata, 32'h55AA);

    // R8 reset mid-run
    @(negedge clk); req[69] = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 summary in reset", 32'(irq), 32'h0);
    req[69] = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(8'h58, v); check("R8 enable cleared", v, 32'h0);
    do_read(8'h50, v); check("R8 pending cleared", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule